// File: doc/BRIEF.md
# Exposure Control Flag Register and Integration Timer

This block is the exposure-control peripheral that the readout sequencer writes over its bus. A sequencer write delivers a 32-bit word together with a strobe. The low half of that word is a set of command bits. Pairs of bits turn level outputs on and off: shutter, preflash, synchronization line, readout busy and pixel-stream enable. Single bits fire one-cycle marker pulses and control the integration timer. The flag register cannot be read back. The host sees its effect only through the outputs and through the condition word.

The integration timer is an up counter that advances on a 1 ms tick. It is compared with a host-loaded integration time. While the timer is running, a host pause input freezes the count and holds shutter and preflash low. Both outputs come back to their stored states once pause is released. The block also records a start-exposure event and its 8-bit vector. It assembles a 16-bit condition word that the sequencer tests in its conditional jumps.

Top module: `expo_ctrl`

## Requirements
- R1: In the cycle after reset is asserted, every level output and every pulse output is 0. The counter is 0 and the start flag and vector are 0. With the integration time at 0 and the user field at 0, the condition word reads 16'h0005.
- R2: A write with wr_en high updates the level outputs in the next cycle. Write bit 4 opens the shutter and bit 5 closes it. Bit 6 turns preflash on and bit 7 turns it off. Bit 10 sets busy and bit 11 clears it. Bit 12 enables the pixel stream and bit 13 disables it. Bit 15 drives sync high and bit 14 drives it low. Bits left at 0 leave their output as it was.
- R3: If both bits of a pair are 1 in the same write, that output keeps its value. This covers the timer start/stop pair (bits 2 and 3) too.
- R4: Write bit 9 gives line_mark_o high for exactly the next cycle. Bit 8 does the same for frame_mark_o and bit 1 for pwr_sync_o. With no such write, the pulse outputs are 0.
- R5: Write bits 31:16 have no effect on any output or on the timer.
- R6: Write bit 2 (without bit 3) clears the counter and starts it. Write bit 3 (without bit 2) stops it. A running counter adds 1 in each cycle in which ms_tick is high and pause is low. A tick in the same cycle as a stop is still counted.
- R7: Condition bit 2 (terminal count) is 1 whenever the counter is greater than or equal to int_time. So it falls when a larger time is loaded and when the counter restarts below the time.
- R8: While pause is high, the counter holds its value and shutter_o and preflash_o are 0. Once pause is low again, both outputs show their stored states. Any set or clear written during the pause is included in those states.
- R9: The counter stops at its all-ones value (CNT_W bits) instead of wrapping.
- R10: A start_cmd pulse sets condition bit 3 and latches start_vec into condition bits 11:4. Write bit 0 clears bit 3 and keeps the vector. If start_cmd and a bit-0 write arrive in the same cycle, start_cmd wins.
- R11: Condition bit 0 is always 1, condition bit 1 equals sync_o, and condition bits 15:12 equal user_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| wr_en | input | 1 | Sequencer write strobe |
| wr_data | input | 32 | Sequencer write word (command bits) |
| int_time | input | CNT_W | Host integration time in ms |
| pause | input | 1 | Host pause: freezes counter, masks shutter and preflash |
| user_bits | input | 4 | Host user field for condition bits 15:12 |
| start_cmd | input | 1 | Start-exposure command pulse |
| start_vec | input | 8 | Vector captured with start_cmd |
| shutter_o | output | 1 | Shutter open level |
| preflash_o | output | 1 | Preflash level |
| sync_o | output | 1 | Synchronization line level |
| busy_o | output | 1 | Readout busy level |
| pix_en_o | output | 1 | Pixel stream enable level |
| line_mark_o | output | 1 | Line marker pulse |
| frame_mark_o | output | 1 | Frame marker pulse |
| pwr_sync_o | output | 1 | Power-synchronization pulse |
| cond_word_o | output | 16 | Condition word for sequencer jumps |

## Verification
The hardest state to reach is the saturated counter. With a 32-bit count, that takes more than four billion millisecond ticks. The bench therefore builds the block with an 8-bit counter, runs it past 255 ticks, and checks that terminal count stays set against the largest integration time, which would fail if the counter wrapped. Pause is asserted rarely and can coincide with pair writes and timer restarts. Directed writes with both bits of every pair set cover the conflict rule. A random stream of full 32-bit words also hits mixed conflicts and upper-half bits.

// File: rtl/expo_pkg.sv
package expo_pkg;

    localparam int WR_W   = 32;
    localparam int COND_W = 16;
    localparam int VEC_W  = 8;
    localparam int USR_W  = 4;
    localparam int N_LVL  = 5;
    localparam int N_PLS  = 3;

    // command bit positions with behavioural meaning
    localparam int B_CLR_START = 0;
    localparam int B_TMR_GO    = 2;
    localparam int B_TMR_HALT  = 3;

    typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_e;

    // level outputs; index 0 is the LSB (shut)
    typedef struct packed {
        logic sync;
        logic pix;
        logic busy;
        logic flash;
        logic shut;
    } lvl_t;

    typedef struct packed {
        logic power;
        logic frame;
        logic line;
    } pls_t;

    function automatic int lvl_on_bit(input int i);
        case (i)
            0:       return 4;
            1:       return 6;
            2:       return 10;
            3:       return 12;
            default: return 15;
        endcase
    endfunction

    function automatic int lvl_off_bit(input int i);
        case (i)
            0:       return 5;
            1:       return 7;
            2:       return 11;
            3:       return 13;
            default: return 14;
        endcase
    endfunction

    function automatic int pls_bit(input int i);
        case (i)
            0:       return 9;
            1:       return 8;
            default: return 1;
        endcase
    endfunction

    // set/clear resolution: conflicting request keeps the current value
    function automatic logic pair_next(input logic cur, input logic on, input logic off);
        if (on && !off)
            return 1'b1;
        else if (off && !on)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/expo_flag_reg.sv
module expo_flag_reg
    import expo_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output lvl_t            lvl_q,
    output pls_t            pls_q
);

    logic [N_LVL-1:0] lvl_vec;
    logic [N_PLS-1:0] pls_vec;

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                lvl_vec[g] <= 1'b0;
            else if (wr_en)
                lvl_vec[g] <= pair_next(lvl_vec[g],
                                        wr_data[lvl_on_bit(g)],
                                        wr_data[lvl_off_bit(g)]);
        end
    end

    for (genvar p = 0; p < N_PLS; p++) begin : g_pls
        always_ff @(posedge clk) begin
            if (rst)
                pls_vec[p] <= 1'b0;
            else
                pls_vec[p] <= wr_en && wr_data[pls_bit(p)];
        end
    end

    assign lvl_q = lvl_t'(lvl_vec);
    assign pls_q = pls_t'(pls_vec);

endmodule

// File: rtl/expo_int_timer.sv
module expo_int_timer
    import expo_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             pause,
    input  logic             go,
    input  logic             halt,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tc
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    tmr_state_e state_q;
    logic       go_eff;
    logic       halt_eff;
    logic       adv;

    assign go_eff   = go && !halt;
    assign halt_eff = halt && !go;
    assign adv      = (state_q == TMR_RUN) && ms_tick && !pause && (cnt_q != CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else if (go_eff) begin
            state_q <= TMR_RUN;
            cnt_q   <= '0;
        end else begin
            if (halt_eff)
                state_q <= TMR_IDLE;
            if (adv)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tc = (cnt_q >= limit);

endmodule

// File: rtl/expo_cond_word.sv
module expo_cond_word
    import expo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cmd,
    input  logic [VEC_W-1:0]  start_vec,
    input  logic              clr_start,
    input  logic              tc,
    input  logic              sync_lvl,
    input  logic [USR_W-1:0]  user_bits,
    output logic [COND_W-1:0] cond_word
);

    logic             flag_q;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            vec_q  <= '0;
        end else if (start_cmd) begin
            flag_q <= 1'b1;
            vec_q  <= start_vec;
        end else if (clr_start) begin
            flag_q <= 1'b0;
        end
    end

    assign cond_word = {user_bits, vec_q, flag_q, tc, sync_lvl, 1'b1};

endmodule

// File: rtl/expo_ctrl.sv
module expo_ctrl
    import expo_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              wr_en,
    input  logic [WR_W-1:0]   wr_data,
    input  logic [CNT_W-1:0]  int_time,
    input  logic              pause,
    input  logic [USR_W-1:0]  user_bits,
    input  logic              start_cmd,
    input  logic [VEC_W-1:0]  start_vec,
    output logic              shutter_o,
    output logic              preflash_o,
    output logic              sync_o,
    output logic              busy_o,
    output logic              pix_en_o,
    output logic              line_mark_o,
    output logic              frame_mark_o,
    output logic              pwr_sync_o,
    output logic [COND_W-1:0] cond_word_o
);

    lvl_t             flag_lvl;
    pls_t             flag_pls;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_tc;
    logic             shut_lvl;
    logic             flash_lvl;

    expo_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .lvl_q   (flag_lvl),
        .pls_q   (flag_pls)
    );

    expo_int_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ms_tick (ms_tick),
        .pause   (pause),
        .go      (wr_en && wr_data[B_TMR_GO]),
        .halt    (wr_en && wr_data[B_TMR_HALT]),
        .limit   (int_time),
        .cnt_q   (tmr_cnt),
        .tc      (tmr_tc)
    );

    expo_cond_word u_cond (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (start_cmd),
        .start_vec (start_vec),
        .clr_start (wr_en && wr_data[B_CLR_START]),
        .tc        (tmr_tc),
        .sync_lvl  (flag_lvl.sync),
        .user_bits (user_bits),
        .cond_word (cond_word_o)
    );

    assign shut_lvl     = flag_lvl.shut;
    assign flash_lvl    = flag_lvl.flash;
    assign shutter_o    = shut_lvl && !pause;
    assign preflash_o   = flash_lvl && !pause;
    assign sync_o       = flag_lvl.sync;
    assign busy_o       = flag_lvl.busy;
    assign pix_en_o     = flag_lvl.pix;
    assign line_mark_o  = flag_pls.line;
    assign frame_mark_o = flag_pls.frame;
    assign pwr_sync_o   = flag_pls.power;

endmodule

// File: rtl/expo_ctrl_chk.sv
module expo_ctrl_chk #(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic              pause,
    input logic              start_cmd,
    input logic              line_mark_o,
    input logic              frame_mark_o,
    input logic [15:0]       cond_word_o,
    input logic              shut_lvl,
    input logic [CNT_W-1:0]  cnt
);

    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    assert_line_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (line_mark_o == $past(wr_en && wr_data[9])));

    assert_frame_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (frame_mark_o == $past(wr_en && wr_data[8])));

    assert_pair_conflict_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr_en && wr_data[4] && wr_data[5])) |-> $stable(shut_lvl));

    assert_pause_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(pause) && !$past(wr_en && wr_data[2] && !wr_data[3]))
            |-> (cnt == $past(cnt)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ($past(cnt) == {CNT_W{1'b1}}) && !$past(wr_en && wr_data[2] && !wr_data[3]))
            |-> (cnt == {CNT_W{1'b1}}));

    assert_start_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(start_cmd)) |-> cond_word_o[3]);

endmodule

bind expo_ctrl expo_ctrl_chk #(.CNT_W(CNT_W)) u_expo_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .pause        (pause),
    .start_cmd    (start_cmd),
    .line_mark_o  (line_mark_o),
    .frame_mark_o (frame_mark_o),
    .cond_word_o  (cond_word_o),
    .shut_lvl     (shut_lvl),
    .cnt          (tmr_cnt)
);

// File: tb/test_expo_ctrl.sv
module test_expo_ctrl;

    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ms_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [TW-1:0] int_time = '0;
    logic          pause = 1'b0;
    logic [3:0]    user_bits = '0;
    logic          start_cmd = 1'b0;
    logic [7:0]    start_vec = '0;
    logic          shutter_o, preflash_o, sync_o, busy_o, pix_en_o;
    logic          line_mark_o, frame_mark_o, pwr_sync_o;
    logic [15:0]   cond_word_o;

    always #10 clk = ~clk;

    expo_ctrl #(.CNT_W(TW)) i_expo_ctrl (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .wr_en(wr_en), .wr_data(wr_data),
        .int_time(int_time), .pause(pause), .user_bits(user_bits),
        .start_cmd(start_cmd), .start_vec(start_vec),
        .shutter_o(shutter_o), .preflash_o(preflash_o), .sync_o(sync_o),
        .busy_o(busy_o), .pix_en_o(pix_en_o), .line_mark_o(line_mark_o),
        .frame_mark_o(frame_mark_o), .pwr_sync_o(pwr_sync_o), .cond_word_o(cond_word_o)
    );

    // reference model, built from the requirements
    logic m_shut, m_flash, m_busy, m_pix, m_sync;
    logic m_line, m_frame, m_power;
    logic [TW-1:0] m_cnt;
    logic m_run, m_sf;
    logic [7:0] m_vec;

    function automatic logic setclr(input logic cur, input logic s, input logic c);
        return (s && !c) ? 1'b1 : ((c && !s) ? 1'b0 : cur);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            {m_shut, m_flash, m_busy, m_pix, m_sync} <= '0;
            {m_line, m_frame, m_power} <= '0;
            m_cnt <= '0; m_run <= 1'b0; m_sf <= 1'b0; m_vec <= '0;
        end else begin
            if (wr_en) begin
                m_shut  <= setclr(m_shut,  wr_data[4],  wr_data[5]);
                m_flash <= setclr(m_flash, wr_data[6],  wr_data[7]);
                m_busy  <= setclr(m_busy,  wr_data[10], wr_data[11]);
                m_pix   <= setclr(m_pix,   wr_data[12], wr_data[13]);
                m_sync  <= setclr(m_sync,  wr_data[15], wr_data[14]);
            end
            m_line  <= wr_en && wr_data[9];
            m_frame <= wr_en && wr_data[8];
            m_power <= wr_en && wr_data[1];
            if (wr_en && wr_data[2] && !wr_data[3]) begin
                m_cnt <= '0; m_run <= 1'b1;
            end else begin
                if (wr_en && wr_data[3] && !wr_data[2]) m_run <= 1'b0;
                if (m_run && ms_tick && !pause && m_cnt != {TW{1'b1}}) m_cnt <= m_cnt + 1'b1;
            end
            if (start_cmd) begin
                m_sf <= 1'b1; m_vec <= start_vec;
            end else if (wr_en && wr_data[0]) begin
                m_sf <= 1'b0;
            end
        end
    end

    int    n_chk = 0;
    int    n_fail = 0;
    string phase = "R1";
    bit    done = 1'b0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual %h expected %h", what, phase, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2/R8 shutter",  {31'd0, shutter_o},  {31'd0, m_shut && !pause});
        chk("R2/R8 preflash", {31'd0, preflash_o}, {31'd0, m_flash && !pause});
        chk("R2 busy",        {31'd0, busy_o},     {31'd0, m_busy});
        chk("R2 pixen",       {31'd0, pix_en_o},   {31'd0, m_pix});
        chk("R2 sync",        {31'd0, sync_o},     {31'd0, m_sync});
        chk("R4 pulses", {29'd0, line_mark_o, frame_mark_o, pwr_sync_o},
                         {29'd0, m_line, m_frame, m_power});
        chk("R7 tc", {31'd0, cond_word_o[2]}, {31'd0, m_cnt >= int_time});
        chk("R10 start", {23'd0, cond_word_o[11:3]}, {23'd0, m_vec, m_sf});
        chk("R11 fixed", {26'd0, cond_word_o[15:12], cond_word_o[1:0]},
                         {26'd0, user_bits, m_sync, 1'b1});
    endtask

    task automatic step(input logic we, input logic [31:0] d, input logic tk);
        @(negedge clk);
        compare_all();
        wr_en = we; wr_data = d; ms_tick = tk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare_all();
        chk("R1 cond reset", {16'd0, cond_word_o}, 32'h0000_0005);
        chk("R1 levels reset", {27'd0, shutter_o, preflash_o, sync_o, busy_o, pix_en_o}, 32'd0);
        rst = 1'b0;
        idle(2);

        phase = "R2";
        step(1'b1, 32'h0000_9450, 1'b0);
        idle(1);
        chk("R2 all on", {27'd0, shutter_o, preflash_o, sync_o, busy_o, pix_en_o}, 32'h1f);
        step(1'b1, 32'h0000_0020, 1'b0);
        idle(1);
        chk("R2 shutter off only", {27'd0, shutter_o, preflash_o, sync_o, busy_o, pix_en_o}, 32'h0f);

        phase = "R3";
        step(1'b1, 32'h0000_fcf0, 1'b0);
        idle(1);
        chk("R3 conflict keeps", {27'd0, shutter_o, preflash_o, sync_o, busy_o, pix_en_o}, 32'h0f);

        phase = "R5";
        step(1'b1, 32'hffff_0000, 1'b0);
        idle(1);
        chk("R5 upper ignored", {24'd0, shutter_o, preflash_o, sync_o, busy_o, pix_en_o,
                                 line_mark_o, frame_mark_o, pwr_sync_o}, 32'h78);

        phase = "R4";
        step(1'b1, 32'h0000_0302, 1'b0);
        idle(1);
        chk("R4 pulse on", {29'd0, line_mark_o, frame_mark_o, pwr_sync_o}, 32'h7);
        idle(1);
        chk("R4 pulse gone", {29'd0, line_mark_o, frame_mark_o, pwr_sync_o}, 32'h0);

        phase = "R6";
        int_time = 8'd5;
        step(1'b1, 32'h0000_0004, 1'b0);
        idle(1);
        chk("R6 restart tc low", {31'd0, cond_word_o[2]}, 32'd0);
        ticks(4);
        idle(1);
        chk("R6 four ticks", {31'd0, cond_word_o[2]}, 32'd0);
        ticks(1);
        idle(1);
        chk("R6 five ticks", {31'd0, cond_word_o[2]}, 32'd1);
        step(1'b1, 32'h0000_0008, 1'b0);
        int_time = 8'd6;
        ticks(3);
        idle(1);
        chk("R6 halted", {31'd0, cond_word_o[2]}, 32'd0);

        phase = "R7";
        int_time = 8'd3;
        idle(1);
        chk("R7 lower time", {31'd0, cond_word_o[2]}, 32'd1);
        step(1'b1, 32'h0000_000c, 1'b0);
        idle(1);
        chk("R7 conflict no restart", {31'd0, cond_word_o[2]}, 32'd1);

        phase = "R8";
        step(1'b1, 32'h0000_0014, 1'b0);
        idle(1);
        pause = 1'b1;
        ticks(5);
        idle(1);
        chk("R8 masked", {30'd0, shutter_o, preflash_o}, 32'd0);
        chk("R8 frozen", {31'd0, cond_word_o[2]}, 32'd0);
        pause = 1'b0;
        idle(1);
        chk("R8 restored", {30'd0, shutter_o, preflash_o}, 32'h3);

        phase = "R9";
        int_time = 8'hff;
        step(1'b1, 32'h0000_0004, 1'b0);
        ticks(300);
        idle(1);
        chk("R9 saturated", {31'd0, cond_word_o[2]}, 32'd1);

        phase = "R10";
        start_vec = 8'ha5;
        start_cmd = 1'b1;
        idle(1);
        start_cmd = 1'b0;
        idle(1);
        chk("R10 latched", {23'd0, cond_word_o[11:3]}, {23'd0, 8'ha5, 1'b1});
        step(1'b1, 32'h0000_0001, 1'b0);
        start_cmd = 1'b1; start_vec = 8'h3c;
        idle(1);
        start_cmd = 1'b0;
        idle(1);
        chk("R10 start wins", {23'd0, cond_word_o[11:3]}, {23'd0, 8'h3c, 1'b1});
        step(1'b1, 32'h0000_0001, 1'b0);
        idle(1);
        chk("R10 cleared", {23'd0, cond_word_o[11:3]}, {23'd0, 8'h3c, 1'b0});

        phase = "R11";
        user_bits = 4'h9;
        idle(1);
        chk("R11 user", {28'd0, cond_word_o[15:12]}, 32'h9);

        phase = "random";
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 3) == 0, $urandom, ($urandom % 2) == 0);
            pause     = ($urandom % 8) == 0;
            start_cmd = ($urandom % 20) == 0;
            start_vec = 8'($urandom);
            if (($urandom % 50) == 0) int_time = 8'($urandom % 64);
            if (($urandom % 100) == 0) user_bits = 4'($urandom);
        end
        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #3ms;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog [%s] actual hung expected done", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule